// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

A purely combinational 32-bit integer execution unit for a scalar pipeline. One operation code picks among add and subtract (each in a trapping and a wrapping flavour), left and right shifts with either a fixed or a register-supplied amount, rotate right, counts of leading ones or leading zeros, and the evaluation of branch conditions. The unit has no clock and no internal state, so every output settles from the current inputs in the same cycle.

The write-back stage uses `wr_en` to decide whether `result` is written to the destination register. A trapping add or subtract that overflows in two's complement raises `ovf_trap` and drops `wr_en`, so the destination keeps its old value while exception logic elsewhere takes over. Condition codes drive only `cond` and never write a register.

Operand roles: the shift and rotate value is `opnd_b`; the immediate amount is `shamt`, and the variable amount is the low five bits of `opnd_a`. Counts and single-operand conditions work on `opnd_a`.

Top module: `alu_int_exec`

## Requirements
- R1: Code 0 (trapping add) gives `result` = `opnd_a` + `opnd_b` mod 2^32; `ovf_trap` is 1 exactly when both operands have equal bit 31 and the sum's bit 31 differs from it; `wr_en` = not `ovf_trap`.
- R2: Code 2 (trapping subtract) gives `result` = `opnd_a` − `opnd_b` mod 2^32; `ovf_trap` is 1 exactly when the operands differ in bit 31 and the difference's bit 31 differs from `opnd_a`'s; `wr_en` = not `ovf_trap`.
- R3: Codes 1 (wrapping add) and 3 (wrapping subtract) give the same modular result with `wr_en` = 1 and `ovf_trap` = 0; no code other than 0 and 2 ever raises `ovf_trap`.
- R4: Codes 4, 5, 6 shift `opnd_b` by `shamt`: left with zero fill, right with zero fill, and right replicating bit 31, respectively; `wr_en` = 1.
- R5: Codes 8, 9, 10 perform the same three shifts by `opnd_a[4:0]`; bits 31..5 of `opnd_a` have no effect on the result.
- R6: Code 7 rotates `opnd_b` right by `shamt`, code 11 by `opnd_a[4:0]`; a rotate amount of zero returns `opnd_b` unchanged.
- R7: Code 12 returns the number of consecutive 1 bits of `opnd_a` counted from bit 31 down, 32 for an all-ones input, zero-extended; `wr_en` = 1.
- R8: Code 13 returns the number of consecutive 0 bits of `opnd_a` counted from bit 31 down, 32 for a zero input, zero-extended; `wr_en` = 1.
- R9: Codes 16..21 set `cond` to, in order, a==b, a!=b, signed a>=b, unsigned a>=b, signed a<b, unsigned a<b.
- R10: Codes 22..25 set `cond` from `opnd_a` alone, signed: a>=0, a>0, a<=0, a<0.
- R11: Condition codes and unused codes (14, 15, 26..31) give `result` = 0 and `wr_en` = 0; unused codes and all non-condition codes give `cond` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | First operand; variable shift amount in bits 4..0 |
| opnd_b | input | 32 | Second operand; shift and rotate value |
| shamt | input | 5 | Immediate shift or rotate amount |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Destination write enable |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| cond | output | 1 | Branch condition outcome |

## Verification
The assertions are immediate checks evaluated whenever the inputs change, so they take for granted that all inputs are driven to known values and that `op_sel` is stable long enough for the combinational outputs to settle. The stimulus changes every input together in one step, away from the bench clock edge, and waits before sampling, so no check observes a half-updated operand set. Unused codes are exercised deliberately, since the assertions must also hold for them.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;

    typedef enum logic [4:0] {
        OP_ADD_TRAP = 5'd0,
        OP_ADD_WRAP = 5'd1,
        OP_SUB_TRAP = 5'd2,
        OP_SUB_WRAP = 5'd3,
        OP_SLL_IMM  = 5'd4,
        OP_SRL_IMM  = 5'd5,
        OP_SRA_IMM  = 5'd6,
        OP_ROR_IMM  = 5'd7,
        OP_SLL_VAR  = 5'd8,
        OP_SRL_VAR  = 5'd9,
        OP_SRA_VAR  = 5'd10,
        OP_ROR_VAR  = 5'd11,
        OP_CNT_ONE  = 5'd12,
        OP_CNT_ZERO = 5'd13,
        OP_C_EQ     = 5'd16,
        OP_C_NE     = 5'd17,
        OP_C_GE     = 5'd18,
        OP_C_GEU    = 5'd19,
        OP_C_LT     = 5'd20,
        OP_C_LTU    = 5'd21,
        OP_C_GEZ    = 5'd22,
        OP_C_GTZ    = 5'd23,
        OP_C_LEZ    = 5'd24,
        OP_C_LTZ    = 5'd25
    } op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROT   = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         ovf_raw
);
    logic [W-1:0] rhs_eff;

    always_comb begin
        rhs_eff = do_sub ? ~rhs : rhs;
        sum     = lhs + rhs_eff + {{(W-1){1'b0}}, do_sub};
        // Signed overflow: the effective operands agree in sign and the
        // outcome disagrees with the left-hand operand.
        ovf_raw = (lhs[W-1] == rhs_eff[W-1]) && (sum[W-1] != lhs[W-1]);
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_int_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  out
);
    localparam logic [SW:0] WIDTH_EXT = W[SW:0];

    logic [SW:0]  back_amt;
    logic [W-1:0] rot_val;

    always_comb begin
        back_amt = WIDTH_EXT - {1'b0, amt};
        // Zero amount is kept apart so no shift by the full width occurs.
        rot_val  = (amt == '0) ? val : ((val >> amt) | (val << back_amt));
    end

    always_comb begin
        unique case (kind)
            SH_LEFT:  out = val << amt;
            SH_RIGHT: out = val >> amt;
            SH_ARITH: out = $unsigned($signed(val) >>> amt);
            SH_ROT:   out = rot_val;
            default:  out = '0;
        endcase
    end
endmodule

// File: rtl/alu_lead_count.sv
module alu_lead_count #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val,
    input  logic          match_one,
    output logic [CW-1:0] count
);
    logic stop;

    always_comb begin
        count = '0;
        stop  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!stop) begin
                if (val[i] == match_one) begin
                    count = count + 1'b1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/alu_cond.sv
module alu_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [3:0]   sel,
    output logic         hit
);
    logic eq, slt, ult, neg, zero;

    always_comb begin
        eq   = (lhs == rhs);
        slt  = ($signed(lhs) < $signed(rhs));
        ult  = (lhs < rhs);
        neg  = lhs[W-1];
        zero = (lhs == '0);
        unique case (sel)
            4'd0:    hit = eq;
            4'd1:    hit = !eq;
            4'd2:    hit = !slt;
            4'd3:    hit = !ult;
            4'd4:    hit = slt;
            4'd5:    hit = ult;
            4'd6:    hit = !neg;
            4'd7:    hit = !neg && !zero;
            4'd8:    hit = neg || zero;
            4'd9:    hit = neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_int_exec.sv
module alu_int_exec
    import alu_int_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [4:0]               op_sel,
    input  logic [WIDTH-1:0]         opnd_a,
    input  logic [WIDTH-1:0]         opnd_b,
    input  logic [$clog2(WIDTH)-1:0] shamt,
    output logic [WIDTH-1:0]         result,
    output logic                     wr_en,
    output logic                     ovf_trap,
    output logic                     cond
);
    localparam int SW = $clog2(WIDTH);
    localparam int CW = SW + 1;

    op_e           op;
    logic [WIDTH-1:0] as_sum;
    logic          as_ovf;
    logic [SW-1:0] sh_amt;
    shift_kind_e   sh_kind;
    logic [WIDTH-1:0] sh_out;
    logic [CW-1:0] lc_count;
    logic          cond_hit;

    assign op      = op_e'(op_sel);
    assign sh_amt  = op_sel[3] ? opnd_a[SW-1:0] : shamt;
    assign sh_kind = shift_kind_e'(op_sel[1:0]);

    alu_addsub #(.W(WIDTH)) u_addsub (
        .lhs     (opnd_a),
        .rhs     (opnd_b),
        .do_sub  (op_sel[1]),
        .sum     (as_sum),
        .ovf_raw (as_ovf)
    );

    alu_shift #(.W(WIDTH), .SW(SW)) u_shift (
        .val  (opnd_b),
        .amt  (sh_amt),
        .kind (sh_kind),
        .out  (sh_out)
    );

    alu_lead_count #(.W(WIDTH), .CW(CW)) u_lead (
        .val       (opnd_a),
        .match_one (~op_sel[0]),
        .count     (lc_count)
    );

    alu_cond #(.W(WIDTH)) u_cond (
        .lhs (opnd_a),
        .rhs (opnd_b),
        .sel (op_sel[3:0]),
        .hit (cond_hit)
    );

    always_comb begin
        result   = '0;
        wr_en    = 1'b0;
        ovf_trap = 1'b0;
        cond     = 1'b0;
        unique case (op)
            OP_ADD_TRAP, OP_SUB_TRAP: begin
                result   = as_sum;
                ovf_trap = as_ovf;
                wr_en    = !as_ovf;
            end
            OP_ADD_WRAP, OP_SUB_WRAP: begin
                result = as_sum;
                wr_en  = 1'b1;
            end
            OP_SLL_IMM, OP_SRL_IMM, OP_SRA_IMM, OP_ROR_IMM,
            OP_SLL_VAR, OP_SRL_VAR, OP_SRA_VAR, OP_ROR_VAR: begin
                result = sh_out;
                wr_en  = 1'b1;
            end
            OP_CNT_ONE, OP_CNT_ZERO: begin
                result = {{(WIDTH-CW){1'b0}}, lc_count};
                wr_en  = 1'b1;
            end
            OP_C_EQ, OP_C_NE, OP_C_GE, OP_C_GEU, OP_C_LT,
            OP_C_LTU, OP_C_GEZ, OP_C_GTZ, OP_C_LEZ, OP_C_LTZ: begin
                cond = cond_hit;
            end
            default: begin
                result = '0;
            end
        endcase
    end
endmodule

// File: rtl/alu_int_exec_chk.sv
module alu_int_exec_chk #(
    parameter int WIDTH = 32
) (
    input logic [4:0]               op_sel,
    input logic [WIDTH-1:0]         opnd_a,
    input logic [WIDTH-1:0]         opnd_b,
    input logic [$clog2(WIDTH)-1:0] shamt,
    input logic [WIDTH-1:0]         result,
    input logic                     wr_en,
    input logic                     ovf_trap,
    input logic                     cond
);
    always_comb begin
        // R1
        ovf_blocks_write_chk: assert (!(ovf_trap && wr_en))
            else $error("overflow with write enabled");
        // R3
        ovf_only_trap_chk: assert (!ovf_trap || op_sel == 5'd0 || op_sel == 5'd2)
            else $error("overflow on non-trapping code %0d", op_sel);
        // R1
        add_mixed_sign_chk: assert (!(op_sel == 5'd0 && opnd_a[WIDTH-1] != opnd_b[WIDTH-1] && ovf_trap))
            else $error("mixed-sign add flagged overflow");
        // R2
        sub_same_sign_chk: assert (!(op_sel == 5'd2 && opnd_a[WIDTH-1] == opnd_b[WIDTH-1] && ovf_trap))
            else $error("same-sign subtract flagged overflow");
        // R6
        ror_zero_chk: assert (!(op_sel == 5'd7 && shamt == '0) || result == opnd_b)
            else $error("zero rotate changed value");
        // R8
        count_range_chk: assert (!(op_sel == 5'd12 || op_sel == 5'd13) || result <= WIDTH)
            else $error("count out of range %0d", result);
        // R11
        cond_no_write_chk: assert (!(cond && wr_en))
            else $error("condition with write enabled");
    end
endmodule

bind alu_int_exec alu_int_exec_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_int_exec_bench.sv
module alu_int_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        wr_en, ovf_trap, cond;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    alu_int_exec u_alu_int_exec (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
        .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap), .cond(cond)
    );

    task automatic drive(input logic [4:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
        #5;
    endtask

    task automatic expect_all(input string tag, input logic [31:0] er,
                              input logic ew, input logic eo, input logic ec);
        checks++;
        if (result !== er || wr_en !== ew || ovf_trap !== eo || cond !== ec) begin
            errors++;
            $display("FAIL %s op=%0d actual res=%h wr=%b ovf=%b cond=%b expected res=%h wr=%b ovf=%b cond=%b",
                     tag, op_sel, result, wr_en, ovf_trap, cond, er, ew, eo, ec);
        end
    endtask

    task automatic t_idle;
        drive(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);
        expect_all("R11", 32'h0, 1'b0, 1'b0, 1'b0);
        drive(5'd14, 32'h1, 32'h1, 5'd0);
        expect_all("R11", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_add_trap;
        drive(5'd0, 32'h0000_0005, 32'hFFFF_FFFD, 5'd0);
        expect_all("R1", 32'h0000_0002, 1'b1, 1'b0, 1'b0);
        drive(5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
        expect_all("R1", 32'h8000_0000, 1'b0, 1'b1, 1'b0);
        drive(5'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);
        expect_all("R1", 32'h0000_0000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_sub_trap;
        drive(5'd2, 32'h0000_0003, 32'h0000_0005, 5'd0);
        expect_all("R2", 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);
        drive(5'd2, 32'h8000_0000, 32'h0000_0001, 5'd0);
        expect_all("R2", 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0);
        drive(5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
        expect_all("R2", 32'h8000_0000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_wrap;
        drive(5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
        expect_all("R3", 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        drive(5'd3, 32'h8000_0000, 32'h0000_0001, 5'd0);
        expect_all("R3", 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_shift_imm;
        drive(5'd4, 32'h0, 32'h0000_00F1, 5'd4);
        expect_all("R4", 32'h0000_0F10, 1'b1, 1'b0, 1'b0);
        drive(5'd5, 32'h0, 32'h8000_0010, 5'd4);
        expect_all("R4", 32'h0800_0001, 1'b1, 1'b0, 1'b0);
        drive(5'd6, 32'h0, 32'h8000_0010, 5'd4);
        expect_all("R4", 32'hF800_0001, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_shift_var;
        drive(5'd8, 32'hFFFF_FFE3, 32'h0000_0001, 5'd17);
        expect_all("R5", 32'h0000_0008, 1'b1, 1'b0, 1'b0);
        drive(5'd10, 32'h0000_0020, 32'h8000_0000, 5'd9);
        expect_all("R5", 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        drive(5'd9, 32'hABCD_003F, 32'h8000_0000, 5'd0);
        expect_all("R5", 32'h0000_0001, 1'b1, 1'b0, 1'b0);
        drive(5'd10, 32'h0000_001F, 32'h8000_0000, 5'd0);
        expect_all("R5", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_rotate;
        drive(5'd7, 32'h0, 32'h1234_5678, 5'd8);
        expect_all("R6", 32'h7812_3456, 1'b1, 1'b0, 1'b0);
        drive(5'd7, 32'h0, 32'h1234_5678, 5'd0);
        expect_all("R6", 32'h1234_5678, 1'b1, 1'b0, 1'b0);
        drive(5'd11, 32'h0000_0021, 32'h0000_0001, 5'd5);
        expect_all("R6", 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        drive(5'd11, 32'hFFFF_FFE0, 32'hDEAD_BEEF, 5'd3);
        expect_all("R6", 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_count;
        drive(5'd12, 32'hFFFF_FFFF, 32'h0, 5'd0);
        expect_all("R7", 32'd32, 1'b1, 1'b0, 1'b0);
        drive(5'd12, 32'hF000_0000, 32'h0, 5'd0);
        expect_all("R7", 32'd4, 1'b1, 1'b0, 1'b0);
        drive(5'd12, 32'h7FFF_FFFF, 32'h0, 5'd0);
        expect_all("R7", 32'd0, 1'b1, 1'b0, 1'b0);
        drive(5'd13, 32'h0000_0000, 32'h0, 5'd0);
        expect_all("R8", 32'd32, 1'b1, 1'b0, 1'b0);
        drive(5'd13, 32'h0000_0001, 32'h0, 5'd0);
        expect_all("R8", 32'd31, 1'b1, 1'b0, 1'b0);
        drive(5'd13, 32'h8000_0000, 32'h0, 5'd0);
        expect_all("R8", 32'd0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_cond_pair;
        drive(5'd16, 32'd5, 32'd5, 5'd0);  expect_all("R9", 32'h0, 1'b0, 1'b0, 1'b1);
        drive(5'd17, 32'd5, 32'd5, 5'd0);  expect_all("R9", 32'h0, 1'b0, 1'b0, 1'b0);
        drive(5'd18, 32'hFFFF_FFFF, 32'd1, 5'd0); expect_all("R9", 32'h0, 1'b0, 1'b0, 1'b0);
        drive(5'd19, 32'hFFFF_FFFF, 32'd1, 5'd0); expect_all("R9", 32'h0, 1'b0, 1'b0, 1'b1);
        drive(5'd20, 32'hFFFF_FFFF, 32'd1, 5'd0); expect_all("R9", 32'h0, 1'b0, 1'b0, 1'b1);
        drive(5'd21, 32'hFFFF_FFFF, 32'd1, 5'd0); expect_all("R9", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_cond_single;
        drive(5'd22, 32'h0, 32'hFFFF_FFFF, 5'd0); expect_all("R10", 32'h0, 1'b0, 1'b0, 1'b1);
        drive(5'd23, 32'h0, 32'hFFFF_FFFF, 5'd0); expect_all("R10", 32'h0, 1'b0, 1'b0, 1'b0);
        drive(5'd24, 32'h0, 32'h1, 5'd0);         expect_all("R10", 32'h0, 1'b0, 1'b0, 1'b1);
        drive(5'd25, 32'h8000_0000, 32'h0, 5'd0); expect_all("R10", 32'h0, 1'b0, 1'b0, 1'b1);
        drive(5'd23, 32'h8000_0000, 32'h0, 5'd0); expect_all("R10", 32'h0, 1'b0, 1'b0, 1'b0);
        drive(5'd23, 32'h0000_0007, 32'h0, 5'd0); expect_all("R10", 32'h0, 1'b0, 1'b0, 1'b1);
        drive(5'd26, 32'd5, 32'd5, 5'd0);         expect_all("R11", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        op_sel = 5'd31; opnd_a = '0; opnd_b = '0; shamt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add_trap();
        t_sub_trap();
        t_wrap();
        t_shift_imm();
        t_shift_var();
        t_rotate();
        t_count();
        t_cond_pair();
        t_cond_single();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule